// File: doc/BRIEF.md
# External Chip-Select and Wait-State Controller

This block sits beside a 24-bit CPU bus and turns each bus-cycle start into the control signals for external devices. Three address windows with fixed ranges may each drive one active-low chip select. Each window has its own enable, bus-width and wait settings. When more than one window matches an address, the window with the lowest index wins. Addresses that hit internal I/O, internal memory or the internal ROM region are never sent to an external device.

When a cycle starts, the block latches the decision for that cycle. It holds the selected chip select low and keeps the ready output low for the programmed number of wait cycles. It then raises ready for exactly one cycle, which ends the access. The fourth wait encoding hands the end of the cycle to an external wait input. Configuration is loaded one window at a time through a write strobe per window and applies to every cycle started after the write.

Top module: `ext_cs_wait`

## Requirements
- R1: Window ranges are fixed. Window 0 covers 0x007F00 to 0x007FFF, window 1 covers 0x0008A0 to 0x007FFF and window 2 covers 0x008000 to 0x3FFFFF, with both bounds inclusive. For an external access, cs_n_o[i] goes low only when window i is enabled and selected, and never outside its range.
- R2: When several enabled windows match, only the lowest-indexed one asserts its chip select and applies its width and wait settings. Window 0 therefore beats window 1 in 0x007F00 to 0x007FFF.
- R3: An access flagged by int_io_hit_i or int_mem_hit_i asserts no chip select, uses 16-bit width (bus16_o=1) and 0 waits.
- R4: With HAS_INT_ROM set, an access to 0xFF0000 to 0xFFFFFF asserts no chip select, uses 16-bit width and 0 waits.
- R5: An external access that no enabled window claims asserts no chip select, uses 8-bit width (bus16_o=0) and 0 waits.
- R6: For wait codes 00, 01 and 10, ready_o is low for 0, 1 or 2 cycles after the cycle in which the start is sampled, then high for exactly one cycle. The chip select is low from the first of those cycles through the ready cycle.
- R7: For wait code 11, ready_o stays low while ext_wait_i is high. It rises in the first access cycle in which ext_wait_i is low (a combinational path from ext_wait_i).
- R8: During an access, bus16_o equals the width bit of the selected window, where 1 means 16-bit and 0 means 8-bit.
- R9: After reset, window 2 is enabled, 16-bit, wait code 10, and windows 0 and 1 are disabled, 8-bit, wait code 00.
- R10: While no access is active, cs_n_o is 3'b111, ready_o is 0 and bus16_o is 0.
- R11: A start strobe raised while an access is in progress is ignored. The running access keeps its chip select, width and timing.
- R12: A write with cfg_we_i[i] high loads cfg_en_i, cfg_wide_i and cfg_wait_i into window i. The new settings apply to accesses started afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | CPU address, sampled with the start strobe |
| cyc_start_i | input | 1 | Bus-cycle start strobe |
| int_io_hit_i | input | 1 | Address hits internal I/O |
| int_mem_hit_i | input | 1 | Address hits internal memory |
| ext_wait_i | input | 1 | External wait request, used by wait code 11 |
| cfg_we_i | input | 3 | Per-window configuration write strobe |
| cfg_en_i | input | 1 | Window enable value to write |
| cfg_wide_i | input | 1 | Width value to write (1 = 16-bit) |
| cfg_wait_i | input | 2 | Wait code value to write |
| cs_n_o | output | 3 | Active-low chip selects, bit i = window i |
| bus16_o | output | 1 | Width of the current access (1 = 16-bit) |
| ready_o | output | 1 | One-cycle pulse that ends the access |

## Verification
Directed accesses cover:
- the first and last byte of each window and the byte just outside it, which separates range bugs from precedence bugs;
- the window 0/1 overlap, with window 0 disabled and then enabled, which shows the fixed precedence;
- internal-hit accesses and internal-ROM accesses aimed at addresses a window would otherwise claim, which show the override.

Each wait code is run. For code 11, a range of external hold lengths is applied, which separates counted waits from externally stretched ones. A second start strobe is also injected in the middle of a waited access. Seeded random accesses with random window reprogramming then exercise mixes of settings that the directed cases do not reach.

// File: rtl/ext_cs_pkg.sv
package ext_cs_pkg;
  localparam int AW   = 24;
  localparam int NWIN = 3;
  localparam int WTW  = 2;

  typedef struct packed {
    logic           en;
    logic           wide;
    logic [WTW-1:0] wt;
  } win_cfg_t;

  localparam logic [WTW-1:0] WT_EXT = 2'b11;

  // index 0 is the rightmost element
  localparam logic [NWIN-1:0][AW-1:0] WIN_LO = {24'h008000, 24'h0008A0, 24'h007F00};
  localparam logic [NWIN-1:0][AW-1:0] WIN_HI = {24'h3FFFFF, 24'h007FFF, 24'h007FFF};
  localparam win_cfg_t [NWIN-1:0]     WIN_RST = {win_cfg_t'(4'b1110), win_cfg_t'(4'b0000),
                                                 win_cfg_t'(4'b0000)};
  localparam logic [AW-1:0]           ROM_LO = 24'hFF0000;
endpackage

// File: rtl/cs_win_reg.sv
module cs_win_reg
  import ext_cs_pkg::*;
#(
  parameter win_cfg_t RST_VAL = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic           en_i,
  input  logic           wide_i,
  input  logic [WTW-1:0] wt_i,
  output win_cfg_t       cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= RST_VAL;
    else if (we_i) cfg_o <= '{en: en_i, wide: wide_i, wt: wt_i};
  end
endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode
  import ext_cs_pkg::*;
#(
  parameter bit HAS_INT_ROM = 1'b1
) (
  input  logic [AW-1:0]        addr_i,
  input  logic                 int_io_hit_i,
  input  logic                 int_mem_hit_i,
  input  win_cfg_t [NWIN-1:0]  cfg_i,
  output logic [NWIN-1:0]      sel_o,
  output logic                 wide_o,
  output logic [WTW-1:0]       wt_o
);
  logic [NWIN-1:0] match;
  logic            internal;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign match[i] = cfg_i[i].en && (addr_i >= WIN_LO[i]) && (addr_i <= WIN_HI[i]);
  end

  assign internal = int_io_hit_i || int_mem_hit_i || (HAS_INT_ROM && (addr_i >= ROM_LO));

  always_comb begin
    sel_o  = '0;
    wide_o = 1'b0;
    wt_o   = '0;
    if (internal) begin
      wide_o = 1'b1;
    end else begin
      // walk down so the lowest matching index wins
      for (int i = NWIN - 1; i >= 0; i--) begin
        if (match[i]) begin
          sel_o    = '0;
          sel_o[i] = 1'b1;
          wide_o   = cfg_i[i].wide;
          wt_o     = cfg_i[i].wt;
        end
      end
    end
  end
endmodule

// File: rtl/cs_wait_seq.sv
module cs_wait_seq
  import ext_cs_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [NWIN-1:0] sel_i,
  input  logic            wide_i,
  input  logic [WTW-1:0]  wt_i,
  input  logic            ext_wait_i,
  output logic [NWIN-1:0] cs_n_o,
  output logic            bus16_o,
  output logic            ready_o,
  output logic            busy_o
);
  logic            active_q, ext_q, wide_q;
  logic [WTW-1:0]  cnt_q;
  logic [NWIN-1:0] sel_q;

  assign ready_o = active_q && (cnt_q == '0) && !(ext_q && ext_wait_i);
  assign busy_o  = active_q;
  assign cs_n_o  = ~sel_q;
  assign bus16_o = wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ext_q    <= 1'b0;
      wide_q   <= 1'b0;
      cnt_q    <= '0;
      sel_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sel_q    <= sel_i;
      wide_q   <= wide_i;
      ext_q    <= (wt_i == WT_EXT);
      cnt_q    <= (wt_i == WT_EXT) ? '0 : wt_i;
    end else if (active_q) begin
      if (ready_o) begin
        active_q <= 1'b0;
        sel_q    <= '0;
        wide_q   <= 1'b0;
        ext_q    <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R6
  ready_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (!ready_o && (cs_n_o == '1)));

  // R6
  two_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (wt_i == 2'b10)) |=> !ready_o ##1 !ready_o ##1 ready_o);

  // R7
  ext_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ext_q && ext_wait_i) |=> busy_o);
endmodule

// File: rtl/ext_cs_wait.sv
module ext_cs_wait
  import ext_cs_pkg::*;
#(
  parameter bit HAS_INT_ROM = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            cyc_start_i,
  input  logic            int_io_hit_i,
  input  logic            int_mem_hit_i,
  input  logic            ext_wait_i,
  input  logic [NWIN-1:0] cfg_we_i,
  input  logic            cfg_en_i,
  input  logic            cfg_wide_i,
  input  logic [WTW-1:0]  cfg_wait_i,
  output logic [NWIN-1:0] cs_n_o,
  output logic            bus16_o,
  output logic            ready_o
);
  win_cfg_t [NWIN-1:0] cfg_q;
  logic [NWIN-1:0]     sel;
  logic                wide, busy, start;
  logic [WTW-1:0]      wt;

  for (genvar i = 0; i < NWIN; i++) begin : g_cfg
    cs_win_reg #(.RST_VAL(WIN_RST[i])) i_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cfg_we_i[i]),
      .en_i   (cfg_en_i),
      .wide_i (cfg_wide_i),
      .wt_i   (cfg_wait_i),
      .cfg_o  (cfg_q[i])
    );
  end

  cs_addr_decode #(.HAS_INT_ROM(HAS_INT_ROM)) i_dec (
    .addr_i        (addr_i),
    .int_io_hit_i  (int_io_hit_i),
    .int_mem_hit_i (int_mem_hit_i),
    .cfg_i         (cfg_q),
    .sel_o         (sel),
    .wide_o        (wide),
    .wt_o          (wt)
  );

  assign start = cyc_start_i && !busy;

  cs_wait_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .sel_i      (sel),
    .wide_i     (wide),
    .wt_i       (wt),
    .ext_wait_i (ext_wait_i),
    .cs_n_o     (cs_n_o),
    .bus16_o    (bus16_o),
    .ready_o    (ready_o),
    .busy_o     (busy)
  );

  // R2
  win0_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && !busy && !int_io_hit_i && !int_mem_hit_i && cfg_q[0].en &&
     (addr_i >= WIN_LO[0]) && (addr_i <= WIN_HI[0])) |=> (cs_n_o == 3'b110));

  // R3
  internal_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && !busy && (int_io_hit_i || int_mem_hit_i))
    |=> ((cs_n_o == '1) && bus16_o && ready_o));

  // R4
  int_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_INT_ROM && cyc_start_i && !busy && (addr_i >= ROM_LO))
    |=> ((cs_n_o == '1) && bus16_o && ready_o));

  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_i && busy && !ready_o) |=> ($stable(cs_n_o) && $stable(bus16_o)));
endmodule

// File: tb/test_ext_cs_wait.sv
`timescale 1ns/1ps
module test_ext_cs_wait;
  localparam time CLK_P = 4ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        start = 1'b0, io = 1'b0, mem = 1'b0, ext_wait = 1'b0;
  logic [2:0]  cfg_we = '0;
  logic        cfg_en = 1'b0, cfg_wide = 1'b0;
  logic [1:0]  cfg_wt = '0;
  logic [2:0]  cs_n;
  logic        bus16, ready;

  int n_chk = 0, n_fail = 0;
  logic       sh_en[3];
  logic       sh_wide[3];
  logic [1:0] sh_wt[3];

  always #(CLK_P/2) clk = ~clk;

  ext_cs_wait i_ext_cs_wait (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cyc_start_i(start),
    .int_io_hit_i(io), .int_mem_hit_i(mem), .ext_wait_i(ext_wait),
    .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_wide_i(cfg_wide), .cfg_wait_i(cfg_wt),
    .cs_n_o(cs_n), .bus16_o(bus16), .ready_o(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void model(input logic [23:0] a, input logic i_io, input logic i_mem,
                                output logic [2:0] ecs, output logic ew, output logic [1:0] ewt);
    logic [23:0] lo[3], hi[3];
    lo[0] = 24'h007F00; hi[0] = 24'h007FFF;
    lo[1] = 24'h0008A0; hi[1] = 24'h007FFF;
    lo[2] = 24'h008000; hi[2] = 24'h3FFFFF;
    ecs = 3'b111; ew = 1'b0; ewt = 2'b00;
    if (i_io || i_mem || a >= 24'hFF0000) begin
      ew = 1'b1;
      return;
    end
    for (int i = 0; i < 3; i++) begin
      if (sh_en[i] && a >= lo[i] && a <= hi[i]) begin
        ecs[i] = 1'b0; ew = sh_wide[i]; ewt = sh_wt[i];
        return;
      end
    end
  endfunction

  task automatic wr_cfg(input int w, input logic e, input logic wd, input logic [1:0] t);
    @(negedge clk);
    cfg_we = 3'b001 << w; cfg_en = e; cfg_wide = wd; cfg_wt = t;
    @(negedge clk);
    cfg_we = '0;
    sh_en[w] = e; sh_wide[w] = wd; sh_wt[w] = t;
  endtask

  task automatic check_idle();
    chk("R10 idle cs_n", 32'(cs_n), 32'h7);
    chk("R10 idle ready", 32'(ready), 32'h0);
    chk("R10 idle bus16", 32'(bus16), 32'h0);
  endtask

  // tag names the requirement the chip-select outcome exercises
  task automatic access(input string tag, input logic [23:0] a, input logic i_io,
                        input logic i_mem, input int hold, input bit glitch);
    logic [2:0] ecs;
    logic ew;
    logic [1:0] ewt;
    int n;
    model(a, i_io, i_mem, ecs, ew, ewt);
    n = (ewt == 2'b11) ? hold : int'(ewt);
    @(negedge clk);
    addr = a; io = i_io; mem = i_mem; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= n + 1; c++) begin
      if (c > 1) @(negedge clk);
      if (glitch && c == 1 && n > 0) begin
        start = 1'b1; addr = 24'h007F40; io = 1'b0; mem = 1'b0;
      end else begin
        start = 1'b0;
      end
      ext_wait = (ewt == 2'b11) && (c <= hold);
      #1;
      chk({tag, " cs_n"}, 32'(cs_n), 32'(ecs));
      chk("R8 bus16", 32'(bus16), 32'(ew));
      chk((ewt == 2'b11) ? "R7 ready" : "R6 ready", 32'(ready), 32'(c == n + 1));
    end
    @(negedge clk);
    start = 1'b0; ext_wait = 1'b0; io = 1'b0; mem = 1'b0;
    #1;
    check_idle();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    sh_en[0] = 0; sh_wide[0] = 0; sh_wt[0] = 0;
    sh_en[1] = 0; sh_wide[1] = 0; sh_wt[1] = 0;
    sh_en[2] = 1; sh_wide[2] = 1; sh_wt[2] = 2'b10;
    repeat (3) @(negedge clk);
    #1;
    check_idle();
    rst_n = 1'b1;

    // R9 reset configuration: window 2 at 16-bit, 2 waits
    access("R9", 24'h008000, 0, 0, 0, 0);
    // R5 windows 0 and 1 disabled after reset
    access("R5", 24'h007F10, 0, 0, 0, 0);
    // R12 enable window 1 as 8-bit, 1 wait
    wr_cfg(1, 1, 0, 2'b01);
    access("R12", 24'h007F10, 0, 0, 0, 0);
    access("R1", 24'h0008A0, 0, 0, 0, 0);
    access("R1", 24'h00089F, 0, 0, 0, 0);
    // R2 window 0 takes the overlap
    wr_cfg(0, 1, 1, 2'b00);
    access("R2", 24'h007F10, 0, 0, 0, 0);
    access("R2", 24'h007FFF, 0, 0, 0, 0);
    access("R1", 24'h007EFF, 0, 0, 0, 0);
    access("R1", 24'h3FFFFF, 0, 0, 0, 0);
    access("R5", 24'h400000, 0, 0, 0, 0);
    access("R4", 24'hFF0000, 0, 0, 0, 0);
    access("R4", 24'hFFFFFF, 0, 0, 0, 0);
    access("R3", 24'h008000, 1, 0, 0, 0);
    access("R3", 24'h007F20, 0, 1, 0, 0);
    access("R3", 24'h007F20, 1, 1, 0, 0);
    // R7 externally stretched cycles
    wr_cfg(2, 1, 1, 2'b11);
    access("R7", 24'h010000, 0, 0, 5, 0);
    access("R7", 24'h010000, 0, 0, 0, 0);
    // R11 second strobe during a 2-wait access
    wr_cfg(2, 1, 0, 2'b10);
    access("R11", 24'h020000, 0, 0, 0, 1);
    // R6 each counted wait code on window 0
    for (int t = 0; t < 3; t++) begin
      wr_cfg(0, 1, t[0], 2'(t));
      access("R6", 24'h007F80, 0, 0, 0, 0);
    end

    for (int k = 0; k < 400; k++) begin
      logic [23:0] a;
      int unsigned r;
      r = $urandom % 8;
      if ($urandom % 4 == 0)
        wr_cfg(int'($urandom % 3), 1'($urandom), 1'($urandom), 2'($urandom));
      case (r)
        0: a = 24'h007F00 + 24'($urandom % 256);
        1: a = 24'h0008A0 + 24'($urandom % 24'h7760);
        2: a = 24'h008000 + 24'($urandom % 24'h3F8000);
        3: a = 24'hFF0000 + 24'($urandom % 24'h10000);
        4: a = 24'h000890 + 24'($urandom % 32);
        5: a = 24'h3FFFF0 + 24'($urandom % 32);
        default: a = 24'($urandom);
      endcase
      access("R1", a, ($urandom % 10) == 0, ($urandom % 10) == 0,
             int'($urandom % 5), ($urandom % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule